// File: doc/BRIEF.md
# Copy Engine Register Front End

This block is the memory-mapped register front end of a multi-channel copy engine. A host issues byte-addressed reads and writes of 8, 16, 32 or 64 bits. The block decodes each access into one of two kinds of window. A global window holds engine-wide registers. Each channel has its own fixed-stride window with its control, status, chain-address, completion-address, error and command registers. The registers carry side effects:

- Some are cleared when read.
- Some are cleared by writing ones.
- One bit becomes set when it is read.
- Two 64-bit addresses can be updated by halves.

The channel sequencers are outside this block. Each channel is seen only through a busy input, a 64-bit status input and a bus of error-set pulses. The block drives a one-cycle command strobe toward the addressed channel.

Accesses are handled one at a time by a small state machine.

- **ST_IDLE** accepts a request. IDLE→DECODE is taken when `req_valid_i` is high.
- **ST_DECODE** decodes the latched request, applies its side effects and registers the response.
  - DECODE→STROBE is taken for a valid byte write to a channel command register.
  - DECODE→IDLE is taken otherwise.
- **ST_STROBE** pulses the command to its channel and clears the command register. STROBE→IDLE is unconditional.

Top module: `cpyeng_regfile`

## Requirements
- R1: Offsets below 0x80 address the global window. Channel n occupies 0x80 bytes starting at 0x80*(n+1). Within a window, only bits 6:0 of the offset select the register. Size codes on `req_size_i` are: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit.
- R2: An access is a decode error if its channel index is at or above NUM_CH, if its offset is unmapped, or if its size does not fit the register. A decode error changes no register and returns read data zero. It also sets `dec_err_o`, which then stays high until reset.
- R3: Global offset 0x00 (8-bit) reads NUM_CH. Global offset 0x01 (8-bit) reads XFER_LOG2. Writes to either are ignored.
- R4: Global offset 0x02 (8-bit) is interrupt control, with the master enable in bit 0. A write loads bit 0 from the written byte. A read returns the current value and then clears the enable.
- R5: Global offset 0x04 (32-bit) is attention status. Each cycle the bits of `attn_set_i` are ORed into it. A read returns the value and clears it; a set arriving in the same cycle survives the clear. Writes are ignored.
- R6: Channel offset 0x00 (16-bit) is control, and resets to 0x0008.
  - A read returns the value and then sets the in-use bit, bit 8.
  - A write replaces every bit except interrupt-disable, bit 3. For bit 3, a written 1 clears it and a written 0 keeps its old value.
- R7: The chain address is 64 bits.
  - A 64-bit write at channel offset 0x10 replaces all 64 bits.
  - A 32-bit write at 0x10 replaces only bits 31:0.
  - A 32-bit write at 0x14 replaces only bits 63:32.
  - Reads at the same offsets and sizes return the matching part.
- R8: The completion address behaves the same way as the chain address, using channel offsets 0x18 (low or whole) and 0x1C (high).
- R9: Channel offset 0x08 (64-bit) reads the channel's status input, with bit 0 forced to 1 while that channel's busy input is low. Writes to it are ignored.
- R10: Channel offset 0x20 (32-bit) is the error register. Bits of the channel's error-set input are ORed in. Writing a 1 clears the matching bit, and a set in the same cycle wins.
- R11: A byte write at channel offset 0x28 latches a command. In the next cycle, `cmd_pulse_o[n]` is high for exactly one cycle and `cmd_code_o` carries the byte. The register then reads back as zero.
- R12: `req_ready_o` is high only in ST_IDLE. `rsp_valid_o` is high for one cycle, two rising edges after the accepting edge. `req_ready_o` stays low for one cycle after acceptance, or for two cycles after a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 64 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rdata_o | output | 64 | Read data, zero-extended; zero for writes and errors |
| dec_err_o | output | 1 | Sticky decode-error flag |
| attn_set_i | input | 32 | Attention bits to set |
| ch_busy_i | input | NUM_CH | Busy flag of each channel sequencer |
| ch_status_i | input | NUM_CH*64 | Status word of each channel, channel 0 in the low bits |
| ch_err_set_i | input | NUM_CH*32 | Error bits to set, per channel |
| cmd_pulse_o | output | NUM_CH | One-cycle command strobe per channel |
| cmd_code_o | output | 8 | Command byte during the strobe, zero otherwise |

## Verification
A request is accepted at a rising edge. The response and the updated error flag become visible after the second rising edge that follows. A command strobe appears in that same cycle, and `req_ready_o` comes back one cycle later for a command write.

The driver raises a request just after a falling edge and lowers it at the next falling edge. At that point it checks that the block is no longer ready. It queues the expected read data and error flag, and the monitor compares them at the falling edge in which `rsp_valid_o` is high.

For command writes, the driver itself samples the strobe at the falling edge after the response edge, and again one edge later to confirm it has ended. Side-effect checks use a follow-up read through the normal port.

// File: rtl/cpyeng_pkg.sv
package cpyeng_pkg;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_G_COUNT,
        TGT_G_CAP,
        TGT_G_INTR,
        TGT_G_ATTN,
        TGT_C_CTRL,
        TGT_C_STAT,
        TGT_C_CHAIN_LO,
        TGT_C_CHAIN_HI,
        TGT_C_CMPL_LO,
        TGT_C_CMPL_HI,
        TGT_C_ERR,
        TGT_C_CMD
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_STROBE
    } fsm_e;

    localparam logic [1:0] SZ_B8  = 2'd0;
    localparam logic [1:0] SZ_B16 = 2'd1;
    localparam logic [1:0] SZ_B32 = 2'd2;
    localparam logic [1:0] SZ_B64 = 2'd3;

    localparam int WIN_BITS = 7;

    localparam logic [6:0] OFF_G_COUNT = 7'h00;
    localparam logic [6:0] OFF_G_CAP   = 7'h01;
    localparam logic [6:0] OFF_G_INTR  = 7'h02;
    localparam logic [6:0] OFF_G_ATTN  = 7'h04;

    localparam logic [6:0] OFF_C_CTRL     = 7'h00;
    localparam logic [6:0] OFF_C_STAT     = 7'h08;
    localparam logic [6:0] OFF_C_CHAIN_LO = 7'h10;
    localparam logic [6:0] OFF_C_CHAIN_HI = 7'h14;
    localparam logic [6:0] OFF_C_CMPL_LO  = 7'h18;
    localparam logic [6:0] OFF_C_CMPL_HI  = 7'h1C;
    localparam logic [6:0] OFF_C_ERR      = 7'h20;
    localparam logic [6:0] OFF_C_CMD      = 7'h28;

    localparam int          CTRL_INTDIS_BIT = 3;
    localparam int          CTRL_INUSE_BIT  = 8;
    localparam logic [15:0] CTRL_RESET      = 16'h0008;

endpackage

// File: rtl/cpyeng_decode.sv
module cpyeng_decode
    import cpyeng_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output tgt_e              tgt_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              bad_o
);
    localparam int IDX_W = ADDR_W - WIN_BITS;

    logic [IDX_W-1:0]    win;
    logic [IDX_W-1:0]    cidx;
    logic [WIN_BITS-1:0] off;

    always_comb begin
        win    = addr_i[ADDR_W-1:WIN_BITS];
        off    = addr_i[WIN_BITS-1:0];
        cidx   = win - 1'b1;
        chan_o = cidx[CH_W-1:0];
        tgt_o  = TGT_NONE;
        if (win == '0) begin
            case (off)
                OFF_G_COUNT: if (size_i == SZ_B8)  tgt_o = TGT_G_COUNT;
                OFF_G_CAP:   if (size_i == SZ_B8)  tgt_o = TGT_G_CAP;
                OFF_G_INTR:  if (size_i == SZ_B8)  tgt_o = TGT_G_INTR;
                OFF_G_ATTN:  if (size_i == SZ_B32) tgt_o = TGT_G_ATTN;
                default:     tgt_o = TGT_NONE;
            endcase
        end else if (int'(cidx) < NUM_CH) begin
            case (off)
                OFF_C_CTRL:     if (size_i == SZ_B16) tgt_o = TGT_C_CTRL;
                OFF_C_STAT:     if (size_i == SZ_B64) tgt_o = TGT_C_STAT;
                OFF_C_CHAIN_LO: if (size_i == SZ_B32 || size_i == SZ_B64) tgt_o = TGT_C_CHAIN_LO;
                OFF_C_CHAIN_HI: if (size_i == SZ_B32) tgt_o = TGT_C_CHAIN_HI;
                OFF_C_CMPL_LO:  if (size_i == SZ_B32 || size_i == SZ_B64) tgt_o = TGT_C_CMPL_LO;
                OFF_C_CMPL_HI:  if (size_i == SZ_B32) tgt_o = TGT_C_CMPL_HI;
                OFF_C_ERR:      if (size_i == SZ_B32) tgt_o = TGT_C_ERR;
                OFF_C_CMD:      if (size_i == SZ_B8)  tgt_o = TGT_C_CMD;
                default:        tgt_o = TGT_NONE;
            endcase
        end
        bad_o = (tgt_o == TGT_NONE);
    end
endmodule

// File: rtl/cpyeng_glob_regs.sv
module cpyeng_glob_regs
    import cpyeng_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int XFER_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_i,
    input  logic        wr_i,
    input  tgt_e        tgt_i,
    input  logic [63:0] wdata_i,
    input  logic [31:0] attn_set_i,
    output logic [63:0] rdata_o
);
    logic        intr_en_q;
    logic [31:0] attn_q;
    logic        rd_intr;
    logic        wr_intr;
    logic        rd_attn;

    assign rd_intr = acc_i && !wr_i && (tgt_i == TGT_G_INTR);
    assign wr_intr = acc_i &&  wr_i && (tgt_i == TGT_G_INTR);
    assign rd_attn = acc_i && !wr_i && (tgt_i == TGT_G_ATTN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_en_q <= 1'b0;
            attn_q    <= '0;
        end else begin
            if (wr_intr)      intr_en_q <= wdata_i[0];
            else if (rd_intr) intr_en_q <= 1'b0;
            attn_q <= (rd_attn ? 32'h0 : attn_q) | attn_set_i;
        end
    end

    always_comb begin
        case (tgt_i)
            TGT_G_COUNT: rdata_o = {56'h0, 8'(NUM_CH)};
            TGT_G_CAP:   rdata_o = {56'h0, 8'(XFER_LOG2)};
            TGT_G_INTR:  rdata_o = {63'h0, intr_en_q};
            TGT_G_ATTN:  rdata_o = {32'h0, attn_q};
            default:     rdata_o = '0;
        endcase
    end

    // R5
    attn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_attn && attn_set_i == 32'h0) |=> (attn_q == 32'h0));

    // R4
    intr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_intr |=> !intr_en_q);
endmodule

// File: rtl/cpyeng_chan_regs.sv
module cpyeng_chan_regs
    import cpyeng_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_i,
    input  logic        wr_i,
    input  tgt_e        tgt_i,
    input  logic [1:0]  size_i,
    input  logic [63:0] wdata_i,
    input  logic        cmd_clr_i,
    input  logic        busy_i,
    input  logic [63:0] status_i,
    input  logic [31:0] err_set_i,
    output logic [63:0] rdata_o,
    output logic [7:0]  cmd_o
);
    logic [15:0] ctrl_q;
    logic [15:0] ctrl_wv;
    logic [63:0] chain_q;
    logic [63:0] cmpl_q;
    logic [31:0] err_q;
    logic [7:0]  cmd_q;
    logic        wr;
    logic        rd;
    logic        full;

    assign wr   = acc_i &&  wr_i;
    assign rd   = acc_i && !wr_i;
    assign full = (size_i == SZ_B64);

    always_comb begin
        ctrl_wv = wdata_i[15:0];
        ctrl_wv[CTRL_INTDIS_BIT] = wdata_i[CTRL_INTDIS_BIT] ? 1'b0 : ctrl_q[CTRL_INTDIS_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            chain_q <= '0;
            cmpl_q  <= '0;
            err_q   <= '0;
            cmd_q   <= '0;
        end else begin
            if (wr && tgt_i == TGT_C_CTRL)      ctrl_q <= ctrl_wv;
            else if (rd && tgt_i == TGT_C_CTRL) ctrl_q[CTRL_INUSE_BIT] <= 1'b1;

            if (wr && tgt_i == TGT_C_CHAIN_LO) begin
                if (full) chain_q <= wdata_i;
                else      chain_q[31:0] <= wdata_i[31:0];
            end else if (wr && tgt_i == TGT_C_CHAIN_HI) begin
                chain_q[63:32] <= wdata_i[31:0];
            end

            if (wr && tgt_i == TGT_C_CMPL_LO) begin
                if (full) cmpl_q <= wdata_i;
                else      cmpl_q[31:0] <= wdata_i[31:0];
            end else if (wr && tgt_i == TGT_C_CMPL_HI) begin
                cmpl_q[63:32] <= wdata_i[31:0];
            end

            err_q <= (err_q & ~((wr && tgt_i == TGT_C_ERR) ? wdata_i[31:0] : 32'h0)) | err_set_i;

            if (cmd_clr_i)                     cmd_q <= '0;
            else if (wr && tgt_i == TGT_C_CMD) cmd_q <= wdata_i[7:0];
        end
    end

    always_comb begin
        case (tgt_i)
            TGT_C_CTRL:     rdata_o = {48'h0, ctrl_q};
            TGT_C_STAT:     rdata_o = {status_i[63:1], status_i[0] | ~busy_i};
            TGT_C_CHAIN_LO: rdata_o = full ? chain_q : {32'h0, chain_q[31:0]};
            TGT_C_CHAIN_HI: rdata_o = {32'h0, chain_q[63:32]};
            TGT_C_CMPL_LO:  rdata_o = full ? cmpl_q : {32'h0, cmpl_q[31:0]};
            TGT_C_CMPL_HI:  rdata_o = {32'h0, cmpl_q[63:32]};
            TGT_C_ERR:      rdata_o = {32'h0, err_q};
            TGT_C_CMD:      rdata_o = {56'h0, cmd_q};
            default:        rdata_o = '0;
        endcase
    end

    assign cmd_o = cmd_q;

    // R11
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr_i |=> (cmd_q == 8'h0));

    // R6
    inuse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && tgt_i == TGT_C_CTRL) |=> ctrl_q[CTRL_INUSE_BIT]);

    // R7
    chain_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt_i == TGT_C_CHAIN_HI) |=> (chain_q[31:0] == $past(chain_q[31:0])));
endmodule

// File: rtl/cpyeng_regfile.sv
module cpyeng_regfile
    import cpyeng_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 16,
    parameter int XFER_LOG2 = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [1:0]           req_size_i,
    input  logic [63:0]          req_wdata_i,
    output logic                 rsp_valid_o,
    output logic [63:0]          rsp_rdata_o,
    output logic                 dec_err_o,
    input  logic [31:0]          attn_set_i,
    input  logic [NUM_CH-1:0]    ch_busy_i,
    input  logic [NUM_CH*64-1:0] ch_status_i,
    input  logic [NUM_CH*32-1:0] ch_err_set_i,
    output logic [NUM_CH-1:0]    cmd_pulse_o,
    output logic [7:0]           cmd_code_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    fsm_e              state_q, state_d;
    logic              rq_write;
    logic [ADDR_W-1:0] rq_addr;
    logic [1:0]        rq_size;
    logic [63:0]       rq_wdata;
    tgt_e              tgt;
    logic [CH_W-1:0]   chan;
    logic              bad;
    logic              acc;
    logic              is_glob;
    logic              g_acc;
    logic [63:0]       g_rdata;
    logic [63:0]       rd_mux;
    logic [7:0]        cmd_mux;
    logic              rsp_valid_q;
    logic [63:0]       rsp_rdata_q;
    logic              dec_err_q;
    logic [NUM_CH-1:0] ch_sel;
    logic [NUM_CH-1:0] ch_acc;
    logic [NUM_CH-1:0] ch_clr;
    logic [63:0]       ch_rdata [NUM_CH];
    logic [7:0]        ch_cmd   [NUM_CH];

    cpyeng_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_decode (
        .addr_i (rq_addr),
        .size_i (rq_size),
        .tgt_o  (tgt),
        .chan_o (chan),
        .bad_o  (bad)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid_i) state_d = ST_DECODE;
            ST_DECODE: state_d = (rq_write && tgt == TGT_C_CMD) ? ST_STROBE : ST_IDLE;
            ST_STROBE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready_o = 1'b0;
        acc         = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready_o = 1'b1;
            ST_DECODE: acc = !bad;
            ST_STROBE: acc = 1'b0;
            default:   acc = 1'b0;
        endcase
        is_glob = (tgt == TGT_G_COUNT) || (tgt == TGT_G_CAP) ||
                  (tgt == TGT_G_INTR)  || (tgt == TGT_G_ATTN);
        g_acc   = acc && is_glob;
        for (int i = 0; i < NUM_CH; i++) begin
            ch_sel[i] = !is_glob && !bad && (chan == CH_W'(i));
            ch_acc[i] = acc && ch_sel[i];
            ch_clr[i] = (state_q == ST_STROBE) && ch_sel[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_write <= 1'b0;
            rq_addr  <= '0;
            rq_size  <= '0;
            rq_wdata <= '0;
        end else if (state_q == ST_IDLE && req_valid_i) begin
            rq_write <= req_write_i;
            rq_addr  <= req_addr_i;
            rq_size  <= req_size_i;
            rq_wdata <= req_wdata_i;
        end
    end

    cpyeng_glob_regs #(.NUM_CH(NUM_CH), .XFER_LOG2(XFER_LOG2)) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (g_acc),
        .wr_i       (rq_write),
        .tgt_i      (tgt),
        .wdata_i    (rq_wdata),
        .attn_set_i (attn_set_i),
        .rdata_o    (g_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        cpyeng_chan_regs u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_i     (ch_acc[g]),
            .wr_i      (rq_write),
            .tgt_i     (tgt),
            .size_i    (rq_size),
            .wdata_i   (rq_wdata),
            .cmd_clr_i (ch_clr[g]),
            .busy_i    (ch_busy_i[g]),
            .status_i  (ch_status_i[g*64 +: 64]),
            .err_set_i (ch_err_set_i[g*32 +: 32]),
            .rdata_o   (ch_rdata[g]),
            .cmd_o     (ch_cmd[g])
        );
    end

    always_comb begin
        rd_mux  = is_glob ? g_rdata : 64'h0;
        cmd_mux = 8'h0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) begin
                rd_mux  = rd_mux | ch_rdata[i];
                cmd_mux = cmd_mux | ch_cmd[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            dec_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= (state_q == ST_DECODE);
            rsp_rdata_q <= (state_q == ST_DECODE && !rq_write && !bad) ? rd_mux : 64'h0;
            dec_err_q   <= dec_err_q | (state_q == ST_DECODE && bad);
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_rdata_o = rsp_rdata_q;
    assign dec_err_o   = dec_err_q;
    assign cmd_pulse_o = ch_clr;
    assign cmd_code_o  = (state_q == ST_STROBE) ? cmd_mux : 8'h0;

    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |=> dec_err_o);

    // R12
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && req_ready_o, 2));

    // R11
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_pulse_o));

    // R11
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_pulse_o) |=> (cmd_pulse_o == '0));
endmodule

// File: tb/cpyeng_regfile_tb_top.sv
module cpyeng_regfile_tb_top;
    localparam int NUM_CH    = 3;
    localparam int ADDR_W    = 16;
    localparam int XFER_LOG2 = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid_i = 1'b0;
    logic                 req_ready_o;
    logic                 req_write_i = 1'b0;
    logic [ADDR_W-1:0]    req_addr_i = '0;
    logic [1:0]           req_size_i = '0;
    logic [63:0]          req_wdata_i = '0;
    logic                 rsp_valid_o;
    logic [63:0]          rsp_rdata_o;
    logic                 dec_err_o;
    logic [31:0]          attn_set_i = '0;
    logic [NUM_CH-1:0]    ch_busy_i = '0;
    logic [NUM_CH*64-1:0] ch_status_i = '0;
    logic [NUM_CH*32-1:0] ch_err_set_i = '0;
    logic [NUM_CH-1:0]    cmd_pulse_o;
    logic [7:0]           cmd_code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] exp_data_q [$];
    bit          exp_err_q  [$];
    string       exp_tag_q  [$];

    always #10 clk = ~clk;

    cpyeng_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .XFER_LOG2(XFER_LOG2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .req_size_i(req_size_i), .req_wdata_i(req_wdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .dec_err_o(dec_err_o),
        .attn_set_i(attn_set_i), .ch_busy_i(ch_busy_i), .ch_status_i(ch_status_i),
        .ch_err_set_i(ch_err_set_i), .cmd_pulse_o(cmd_pulse_o), .cmd_code_o(cmd_code_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expectations as responses appear.
    always @(negedge clk) begin
        if (rst_n && rsp_valid_o) begin
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R12 unexpected response", rsp_rdata_o, 64'h0);
            end else begin
                automatic logic [63:0] ed = exp_data_q.pop_front();
                automatic bit          ee = exp_err_q.pop_front();
                automatic string       tg = exp_tag_q.pop_front();
                check(rsp_rdata_o == ed, {tg, " data"}, rsp_rdata_o, ed);
                check(dec_err_o == ee, {tg, " dec_err"}, 64'(dec_err_o), 64'(ee));
            end
        end
    end

    // Driver: one access; pushes the expected response.
    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                          input logic [63:0] wd, input logic [63:0] exp, input bit experr,
                          input string tag, input int cmd_ch = -1);
        exp_data_q.push_back(wr ? 64'h0 : exp);
        exp_err_q.push_back(experr);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a;
        req_size_i = sz; req_wdata_i = wd;
        @(negedge clk);
        req_valid_i = 1'b0;
        check(req_ready_o == 1'b0, "R12 ready low in decode", 64'(req_ready_o), 64'h0);
        @(negedge clk);
        if (cmd_ch >= 0) begin
            check(cmd_pulse_o == NUM_CH'(1 << cmd_ch), "R11 pulse", 64'(cmd_pulse_o), 64'(1 << cmd_ch));
            check(cmd_code_o == wd[7:0], "R11 code", 64'(cmd_code_o), 64'(wd[7:0]));
            @(negedge clk);
            check(cmd_pulse_o == '0, "R11 pulse ends", 64'(cmd_pulse_o), 64'h0);
        end
        while (!req_ready_o) @(negedge clk);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [63:0] exp,
                      input string tag, input bit experr = 1'b0);
        access(1'b0, a, sz, 64'h0, exp, experr, tag);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [63:0] wd,
                      input string tag, input bit experr = 1'b0);
        access(1'b1, a, sz, wd, 64'h0, experr, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(req_ready_o == 1'b1, "R12 reset ready", 64'(req_ready_o), 64'h1);
        check(rsp_valid_o == 1'b0, "R12 reset rsp_valid", 64'(rsp_valid_o), 64'h0);
        check(dec_err_o == 1'b0, "R2 reset dec_err", 64'(dec_err_o), 64'h0);
        check(cmd_pulse_o == '0, "R11 reset pulse", 64'(cmd_pulse_o), 64'h0);

        // R3 / R1 global window
        rd(16'h0000, 2'd0, 64'd3, "R3 count");
        rd(16'h0001, 2'd0, 64'd12, "R3 cap");
        wr(16'h0000, 2'd0, 64'hFF, "R3 count write");
        rd(16'h0000, 2'd0, 64'd3, "R3 count unchanged");

        // R4 interrupt control
        rd(16'h0002, 2'd0, 64'h0, "R4 reset");
        wr(16'h0002, 2'd0, 64'h1, "R4 write");
        rd(16'h0002, 2'd0, 64'h1, "R4 read set");
        rd(16'h0002, 2'd0, 64'h0, "R4 cleared by read");

        // R5 attention status
        @(negedge clk); attn_set_i = 32'h00F0_0001;
        @(negedge clk); attn_set_i = 32'h0;
        rd(16'h0004, 2'd2, 64'h00F0_0001, "R5 read");
        rd(16'h0004, 2'd2, 64'h0, "R5 cleared");
        @(negedge clk); attn_set_i = 32'h0000_0100;
        @(negedge clk); attn_set_i = 32'h0;
        wr(16'h0004, 2'd2, 64'hFFFF_FFFF, "R5 write ignored");
        rd(16'h0004, 2'd2, 64'h100, "R5 after write");

        // R6 channel 0 control (window 0x80)
        rd(16'h0080, 2'd1, 64'h0008, "R6 reset");
        rd(16'h0080, 2'd1, 64'h0108, "R6 in-use set");
        wr(16'h0080, 2'd1, 64'hF0F0, "R6 write 0 keeps intdis");
        rd(16'h0080, 2'd1, 64'hF0F8, "R6 after write");
        rd(16'h0080, 2'd1, 64'hF1F8, "R6 in-use again");
        wr(16'h0080, 2'd1, 64'h0008, "R6 write 1 clears intdis");
        rd(16'h0080, 2'd1, 64'h0000, "R6 intdis cleared");

        // R7 channel 1 chain address (window 0x100)
        wr(16'h0110, 2'd3, 64'h1122_3344_5566_7788, "R7 full write");
        rd(16'h0110, 2'd3, 64'h1122_3344_5566_7788, "R7 full read");
        wr(16'h0114, 2'd2, 64'hDEAD_BEEF, "R7 high write");
        rd(16'h0110, 2'd3, 64'hDEAD_BEEF_5566_7788, "R7 high only");
        wr(16'h0110, 2'd2, 64'h0BAD_F00D, "R7 low write");
        rd(16'h0114, 2'd2, 64'hDEAD_BEEF, "R7 high kept");
        rd(16'h0110, 2'd2, 64'h0BAD_F00D, "R7 low read");

        // R8 channel 2 completion address (window 0x180)
        wr(16'h019C, 2'd2, 64'h1234_5678, "R8 high write");
        wr(16'h0198, 2'd2, 64'h9ABC_DEF0, "R8 low write");
        rd(16'h0198, 2'd3, 64'h1234_5678_9ABC_DEF0, "R8 full read");

        // R9 status of channel 1
        ch_status_i[64 +: 64] = 64'hA5A5_0000_1234_5670;
        ch_busy_i = 3'b000;
        rd(16'h0108, 2'd3, 64'hA5A5_0000_1234_5671, "R9 idle");
        ch_busy_i = 3'b010;
        rd(16'h0108, 2'd3, 64'hA5A5_0000_1234_5670, "R9 busy");
        wr(16'h0108, 2'd3, 64'h0, "R9 write ignored");
        rd(16'h0108, 2'd3, 64'hA5A5_0000_1234_5670, "R9 after write");

        // R10 channel 0 error register
        @(negedge clk); ch_err_set_i[31:0] = 32'h0000_00FF;
        @(negedge clk); ch_err_set_i[31:0] = 32'h0;
        rd(16'h00A0, 2'd2, 64'hFF, "R10 set");
        wr(16'h00A0, 2'd2, 64'h0F, "R10 w1c");
        rd(16'h00A0, 2'd2, 64'hF0, "R10 after clear");

        // R11 command to channel 2
        access(1'b1, 16'h01A8, 2'd0, 64'h5A, 64'h0, 1'b0, "R11 command write", 2);
        rd(16'h01A8, 2'd0, 64'h0, "R11 command cleared");

        // R2 decode errors
        wr(16'h0110, 2'd1, 64'hFFFF, "R2 bad size write", 1'b1);
        rd(16'h0110, 2'd3, 64'hDEAD_BEEF_0BAD_F00D, "R2 no update", 1'b1);
        rd(16'h0200, 2'd3, 64'h0, "R2 channel out of range", 1'b1);
        rd(16'h0086, 2'd1, 64'h0, "R2 unmapped offset", 1'b1);
        rd(16'h0004, 2'd0, 64'h0, "R2 wrong size global", 1'b1);

        repeat (4) @(negedge clk);
        check(exp_data_q.size() == 0, "R12 all responses seen", 64'(exp_data_q.size()), 64'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule